// File: doc/BRIEF.md
# Filtered Event Counter Slice

This block is one slice of a performance counter. On every clock it receives a multi-bit count of how many times the watched event happened in that cycle, the current privilege level, and a set of control inputs. From these it decides how much to add to a 48-bit accumulator. A privilege filter picks user levels, kernel level or both. An 8-bit threshold turns the raw count into a per-cycle condition. An invert flag flips that condition, and an edge flag counts only the starts of qualifying runs.

Software loads the accumulator through a write strobe and reads it continuously. A sticky overflow flag records a wrap past the top. A sticky configuration-error flag records any attempt to use edge counting without a threshold. Such a setting freezes the accumulator for as long as it is applied.

Top module: `pmc_slice`

## Requirements
- R1: While `cfg_en` is 0 and no write is made, `cnt_val` keeps its value.
- R2: A cycle passes the privilege filter when `priv_lvl` is 0 and `cfg_os` is 1, or when `priv_lvl` is 1, 2 or 3 and `cfg_usr` is 1. With both flags set, every level passes. With neither set, nothing is counted.
- R3: With `cfg_thresh` equal to 0 and no edge flag, the accumulator adds the full `evt_cnt` on each cycle that passes the filter, and `cfg_inv` has no effect.
- R4: With `cfg_thresh` nonzero, the accumulator adds 1 on each filtered cycle where `evt_cnt` >= `cfg_thresh`.
- R5: With `cfg_thresh` nonzero and `cfg_inv` set, it adds 1 on each filtered cycle where `evt_cnt` < `cfg_thresh`.
- R6: With `cfg_edge` set and a nonzero threshold, it adds 1 only when a qualifying cycle (filter passed and condition met) follows a non-qualifying one. The stored previous state starts non-qualifying after reset and is cleared in every cycle the counter is disabled.
- R7: `cfg_edge` set with `cfg_thresh` 0 while enabled is illegal. The accumulator stays frozen and `cfg_err` becomes 1 on the next clock, then stays 1 until a write.
- R8: A cycle with `wr_en` high loads `wr_data` into `cnt_val` on the next clock. The load takes priority over any increment, and it clears `ovf_flag` and `cfg_err`. After reset all three outputs are 0.
- R9: When an addition carries past 2^48-1, the accumulator keeps the low 48 bits and `ovf_flag` becomes 1, staying 1 until a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_cnt | input | 4 | Event occurrences this cycle |
| priv_lvl | input | 2 | Current privilege level (0 = kernel) |
| cfg_en | input | 1 | Counter enable |
| cfg_usr | input | 1 | Count at levels 1 to 3 |
| cfg_os | input | 1 | Count at level 0 |
| cfg_inv | input | 1 | Invert threshold condition |
| cfg_edge | input | 1 | Count rising edges of the condition only |
| cfg_thresh | input | 8 | Occurrence threshold (0 = raw add) |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 48 | Value to load |
| cnt_val | output | 48 | Accumulator value |
| ovf_flag | output | 1 | Sticky overflow |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
On every cycle the assertions check several properties. The accumulator holds while disabled and stays frozen under the illegal setting. A write loads exactly the written value. Both sticky flags persist until a write. In threshold modes each step is at most one, and edge mode never yields two pulses in a row. Only the bench scenarios can show the actual amounts added. These depend on the comparison against the threshold, the inversion, the choice of privilege level, the exact edge positions after a disable, and the wrap point. They are checked against a behavioural reference model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int PMC_THR_W = 8;

   typedef struct packed {
      logic                 en;
      logic                 usr;
      logic                 os;
      logic                 inv;
      logic                 edge_det;
      logic [PMC_THR_W-1:0] thr;
   } pmc_ctrl_t;
endpackage

// File: rtl/pmc_qualify.sv
module pmc_qualify
   import pmc_pkg::*;
#(
   parameter int EVT_W = 4
) (
   input  logic [EVT_W-1:0] evt,
   input  logic [1:0]       priv,
   input  pmc_ctrl_t        ctrl,
   output logic             priv_ok,
   output logic             raw_mode,
   output logic             qual
);
   localparam int CMP_W = (EVT_W > PMC_THR_W) ? EVT_W : PMC_THR_W;

   logic [CMP_W-1:0] evt_x;
   logic [CMP_W-1:0] thr_x;
   logic             meets;

   always_comb begin
      evt_x    = CMP_W'(evt);
      thr_x    = CMP_W'(ctrl.thr);
      priv_ok  = (priv == 2'd0) ? ctrl.os : ctrl.usr;
      raw_mode = (ctrl.thr == '0);
      meets    = (evt_x >= thr_x);
      qual     = priv_ok & (meets ^ ctrl.inv);
   end
endmodule

// File: rtl/pmc_edge.sv
module pmc_edge #(
   parameter bit HAS_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic edge_sel,
   input  logic qual,
   output logic pulse
);
   generate
      if (HAS_EDGE) begin : g_edge
         logic prev_q;

         always_ff @(posedge clk) begin
            if (!rst_n)   prev_q <= 1'b0;
            else if (clr) prev_q <= 1'b0;
            else          prev_q <= qual;
         end

         always_comb pulse = edge_sel ? (qual & ~prev_q) : qual;

         AST_EDGE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sel && pulse && !clr) |=> !(edge_sel && pulse)) else $error("edge repeat"); // R6
      end else begin : g_level
         always_comb pulse = qual;
      end
   endgenerate
endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
   parameter int CNT_W = 48,
   parameter int INC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   logic [CNT_W:0] sum;

   always_comb sum = {1'b0, cnt} + (CNT_W+1)'(inc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (wr_en) begin
         cnt <= wr_data;
         ovf <= 1'b0;
      end else begin
         cnt <= sum[CNT_W-1:0];
         ovf <= ovf | sum[CNT_W];
      end
   end

   AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt == $past(wr_data))) else $error("write load"); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !wr_en) |=> ovf) else $error("ovf sticky"); // R9
endmodule

// File: rtl/pmc_slice.sv
module pmc_slice
   import pmc_pkg::*;
#(
   parameter int CNT_W    = 48,
   parameter int EVT_W    = 4,
   parameter bit HAS_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_cnt,
   input  logic [1:0]       priv_lvl,
   input  logic             cfg_en,
   input  logic             cfg_usr,
   input  logic             cfg_os,
   input  logic             cfg_inv,
   input  logic             cfg_edge,
   input  logic [7:0]       cfg_thresh,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt_val,
   output logic             ovf_flag,
   output logic             cfg_err
);
   generate
      if (CNT_W <= EVT_W) begin : g_bad_width
         $error("CNT_W must exceed EVT_W");
      end
      if (PMC_THR_W != 8) begin : g_bad_thr
         $error("threshold field must be 8 bits");
      end
   endgenerate

   pmc_ctrl_t        ctrl;
   logic             priv_ok;
   logic             raw_mode;
   logic             qual;
   logic             pulse;
   logic             illegal;
   logic             run;
   logic [EVT_W-1:0] inc;

   always_comb begin
      ctrl.en       = cfg_en;
      ctrl.usr      = cfg_usr;
      ctrl.os       = cfg_os;
      ctrl.inv      = cfg_inv;
      ctrl.edge_det = cfg_edge & HAS_EDGE;
      ctrl.thr      = cfg_thresh;
   end

   pmc_qualify #(.EVT_W(EVT_W)) u_qual (
      .evt      (evt_cnt),
      .priv     (priv_lvl),
      .ctrl     (ctrl),
      .priv_ok  (priv_ok),
      .raw_mode (raw_mode),
      .qual     (qual)
   );

   always_comb begin
      illegal = ctrl.en & ctrl.edge_det & raw_mode;
      run     = ctrl.en & ~illegal;
      if (!run)          inc = '0;
      else if (raw_mode) inc = priv_ok ? evt_cnt : '0;
      else               inc = EVT_W'(pulse);
   end

   pmc_edge #(.HAS_EDGE(HAS_EDGE)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~run),
      .edge_sel (ctrl.edge_det),
      .qual     (qual),
      .pulse    (pulse)
   );

   pmc_accum #(.CNT_W(CNT_W), .INC_W(EVT_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .inc     (inc),
      .cnt     (cnt_val),
      .ovf     (ovf_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     cfg_err <= 1'b0;
      else if (wr_en) cfg_err <= 1'b0;
      else            cfg_err <= cfg_err | illegal;
   end

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !wr_en) |=> $stable(cnt_val)) else $error("hold off"); // R1
   AST_FROZEN_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && cfg_edge && cfg_thresh == 8'd0 && !wr_en) |=> $stable(cnt_val)) else $error("frozen"); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !wr_en) |=> cfg_err) else $error("err sticky"); // R7
   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_thresh != 8'd0 && !wr_en) |=>
         (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + 1'b1)) else $error("step"); // R4
endmodule

// File: tb/pmc_slice_test.sv
module pmc_slice_test;
   localparam int CW = 48;
   localparam longint unsigned MASK = (64'd1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    evt_cnt = '0;
   logic [1:0]    priv_lvl = '0;
   logic          cfg_en = 0, cfg_usr = 0, cfg_os = 0, cfg_inv = 0, cfg_edge = 0;
   logic [7:0]    cfg_thresh = '0;
   logic          wr_en = 0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] cnt_val;
   logic          ovf_flag, cfg_err;

   int errors = 0;
   int checks = 0;
   string cur_req = "R8";

   longint unsigned m_cnt = 0;
   bit m_ovf = 0, m_err = 0, m_prev = 0;

   pmc_slice uut (
      .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .priv_lvl(priv_lvl),
      .cfg_en(cfg_en), .cfg_usr(cfg_usr), .cfg_os(cfg_os), .cfg_inv(cfg_inv),
      .cfg_edge(cfg_edge), .cfg_thresh(cfg_thresh), .wr_en(wr_en),
      .wr_data(wr_data), .cnt_val(cnt_val), .ovf_flag(ovf_flag), .cfg_err(cfg_err)
   );

   always #5 clk = ~clk;

   // behavioural reference model
   always @(posedge clk) begin
      bit pok, q, bad, run;
      longint unsigned add, s;
      if (!rst_n) begin
         m_cnt = 0; m_ovf = 0; m_err = 0; m_prev = 0;
      end else begin
         pok = (priv_lvl == 0) ? cfg_os : cfg_usr;
         q   = pok && ((int'(evt_cnt) >= int'(cfg_thresh)) != cfg_inv);
         bad = cfg_en && cfg_edge && (cfg_thresh == 0);
         run = cfg_en && !bad;
         add = 0;
         if (run) begin
            if (cfg_thresh == 0) add = pok ? longint'(evt_cnt) : 0;
            else if (cfg_edge)   add = (q && !m_prev) ? 1 : 0;
            else                 add = q ? 1 : 0;
         end
         if (wr_en) begin
            m_cnt = longint'(wr_data); m_ovf = 0; m_err = 0;
         end else begin
            s = m_cnt + add;
            if (s > MASK) m_ovf = 1;
            m_cnt = s & MASK;
            if (bad) m_err = 1;
         end
         m_prev = run ? q : 0;
      end
   end

   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         checks++;
         if (longint'(cnt_val) != m_cnt || ovf_flag != m_ovf || cfg_err != m_err) begin
            errors++;
            $display("FAIL %s model: cnt=%0d ovf=%0d err=%0d expected cnt=%0d ovf=%0d err=%0d",
                     cur_req, cnt_val, ovf_flag, cfg_err, m_cnt, m_ovf, m_err);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write(input longint unsigned v);
      wr_en = 1; wr_data = v[CW-1:0]; cyc(1); wr_en = 0;
   endtask

   task automatic cfg(input bit en, input bit u, input bit k, input bit inv,
                      input bit edg, input int thr);
      cfg_en = en; cfg_usr = u; cfg_os = k; cfg_inv = inv; cfg_edge = edg;
      cfg_thresh = thr[7:0];
   endtask

   task automatic feed(input int v);
      evt_cnt = v[3:0]; cyc(1);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      chk("R8 reset cnt", cnt_val, 0);
      chk("R8 reset ovf", ovf_flag, 0);
      chk("R8 reset err", cfg_err, 0);

      cur_req = "R1";
      cfg(0, 1, 1, 0, 0, 0); evt_cnt = 5; cyc(5);
      chk("R1 disabled hold", cnt_val, 0);

      cur_req = "R3";
      priv_lvl = 3; cfg(1, 1, 0, 0, 0, 0); evt_cnt = 3; cyc(4);
      chk("R3 raw add", cnt_val, 12);
      cfg_inv = 1; cyc(2);
      chk("R3 invert ignored", cnt_val, 18);

      cur_req = "R2";
      cfg(1, 1, 0, 0, 0, 0); priv_lvl = 0; cyc(3);
      chk("R2 user-only at level 0", cnt_val, 18);
      cfg(1, 0, 1, 0, 0, 0); evt_cnt = 2; cyc(2);
      chk("R2 kernel at level 0", cnt_val, 22);
      priv_lvl = 2; cyc(2);
      chk("R2 kernel-only at level 2", cnt_val, 22);
      cfg(1, 1, 1, 0, 0, 0); priv_lvl = 1; cyc(1); priv_lvl = 0; cyc(1);
      chk("R2 both levels", cnt_val, 26);
      cfg(1, 0, 0, 0, 0, 0); cyc(2);
      chk("R2 neither", cnt_val, 26);

      cur_req = "R4";
      write(0);
      priv_lvl = 2; cfg(1, 1, 0, 0, 0, 4);
      feed(2); feed(4); feed(7); feed(3); feed(4);
      chk("R4 threshold ge", cnt_val, 3);

      cur_req = "R5";
      write(0); cfg_inv = 1;
      feed(2); feed(4); feed(7); feed(3); feed(4);
      chk("R5 inverted", cnt_val, 2);

      cur_req = "R6";
      cfg_en = 0; evt_cnt = 0; cyc(1);
      write(0);
      cfg(1, 1, 0, 0, 1, 4);
      feed(5); feed(5); feed(1); feed(5); feed(5); feed(5); feed(0);
      chk("R6 edge count", cnt_val, 2);
      evt_cnt = 5; cyc(2);
      cfg_en = 0; cyc(1); cfg_en = 1; cyc(2);
      chk("R6 cleared by disable", cnt_val, 4);
      priv_lvl = 0; cyc(1); priv_lvl = 1; cyc(1);
      chk("R6 filter breaks run", cnt_val, 5);

      cur_req = "R7";
      cfg(1, 1, 0, 0, 1, 0); evt_cnt = 3; cyc(3);
      chk("R7 frozen", cnt_val, 5);
      chk("R7 err set", cfg_err, 1);
      cfg_edge = 0; cyc(2);
      chk("R7 err sticky", cfg_err, 1);
      chk("R7 resumes", cnt_val, 11);
      cur_req = "R8";
      write(100);
      chk("R8 write clears err", cfg_err, 0);
      chk("R8 write loads", cnt_val, 100);
      wr_en = 1; wr_data = 48'd7; evt_cnt = 9; cyc(1); wr_en = 0; evt_cnt = 0;
      chk("R8 write beats increment", cnt_val, 7);

      cur_req = "R9";
      write(MASK - 2);
      evt_cnt = 2; cyc(1);
      chk("R9 reach top", cnt_val, MASK);
      chk("R9 no ovf yet", ovf_flag, 0);
      cyc(1);
      chk("R9 wrapped value", cnt_val, 1);
      chk("R9 ovf set", ovf_flag, 1);
      evt_cnt = 0; cyc(3);
      chk("R9 ovf sticky", ovf_flag, 1);
      write(0);
      chk("R8 write clears ovf", ovf_flag, 0);

      cur_req = "R2/R4/R6 random";
      for (int i = 0; i < 2000; i++) begin
         evt_cnt = 4'($urandom_range(0, 15));
         priv_lvl = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 7) == 0) begin
            cfg_en = ($urandom_range(0, 4) != 0);
            cfg_usr = 1'($urandom); cfg_os = 1'($urandom);
            cfg_inv = 1'($urandom); cfg_edge = ($urandom_range(0, 3) == 0);
            cfg_thresh = 8'($urandom_range(0, 9));
         end
         wr_en = ($urandom_range(0, 40) == 0);
         wr_data = (($urandom_range(0, 1) == 1) ? (MASK - 20) : 64'd0) + 48'($urandom_range(0, 10));
         cyc(1);
      end
      wr_en = 0;
      cyc(2);
      summary();
   end
endmodule